// File: doc/BRIEF.md
# Multi-Channel Reset Delay Supervisor

This block turns the digital verdicts of external voltage comparators into four active-low reset lines. Each line is pulled low at once when its rail leaves the healthy range. It is let go only after the rail has stayed healthy for a chosen number of timebase ticks. The first line also obeys an active-low manual reset request. The fourth line watches a window: a rail can be too low or too high, and both are faults.

The release delay of each channel is picked on its own from three settings: a long fixed delay (300 ticks), a short fixed delay (20 ticks), or a count that software or straps load into a 14-bit field. The timebase is a one-cycle enable strobe, nominally 1 kHz, so the defaults give 300 ms and 20 ms. The programmable field spans well past the 1.4 ms to 10 s range. All comparator flags and the manual reset arrive asynchronously and pass through two-flop synchronizers first.

Top module: `rst_delay_sup`

## Requirements
- R1: For channels 1 to 3, a high on the matching `sense_low` bit (bit 0, 1 or 2; 1 means the rail is below threshold) drives that channel's `rst_out_n` bit low.
- R2: Channel 1 (`rst_out_n[0]`) is also driven low while `mr_n` is low. It starts its release delay only once `mr_n` is high and `sense_low[0]` is low.
- R3: Channel 4 (`rst_out_n[3]`) is driven low when `sense_low[3]` is high or when `over_hi` is high (1 means the rail is above its upper threshold). It is healthy only when both are low.
- R4: Assertion needs no tick and waits for no delay. The output falls as soon as the synchronized fault is seen, and it falls for no other reason.
- R5: Release is counted only on cycles where `tick` is high. With a delay of N ticks, the output rises at the clock edge of the N-th tick that follows the synchronized healthy condition.
- R6: `dly_sel[2i+1:2i]` picks channel i's delay: 2'b00 long (LONG_TICKS, default 300), 2'b01 short (SHORT_TICKS, default 20), 2'b10 programmable, 2'b11 treated as long. Channels are independent.
- R7: In programmable mode the delay is `prog_ticks[14i+13:14i]` ticks. A value of 0 acts as 1 tick, and the full 14-bit range up to 16383 is honoured.
- R8: Any fault while a channel is counting clears its count, including a fault that arrives on the very edge the delay would end. The next release needs the full delay again, timed from when the fault clears.
- R9: During and after the synchronous reset (`rst_n` low) all four outputs are low. Counting starts only when the synchronized inputs are healthy.
- R10: Each input passes through two flops. A change applied between edges reaches the output after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase enable strobe, one cycle per tick |
| sense_low | input | 4 | Per-channel below-threshold flags, 1 = below |
| over_hi | input | 1 | Channel 4 above-upper-threshold flag, 1 = above |
| mr_n | input | 1 | Active-low manual reset for channel 1 |
| dly_sel | input | 8 | Two-bit delay mode per channel |
| prog_ticks | input | 56 | 14-bit programmable delay per channel |
| rst_out_n | output | 4 | Active-low reset outputs |

## Verification
A fault and the end of a release delay can land in the same cycle. In that cycle the counter would reach its target just as the synchronized fault appears. The bench provokes this by clearing a fault and then pulsing it again one cycle, timed so that the synchronized fault is present on exactly the edge that would have released the channel. The fault must win: the output stays low, and release then takes the full delay again from the moment the pulse clears. The bench also makes the manual reset hand over to a sense fault in the same cycle, so channel 1 never sees a healthy gap.

// File: rtl/rst_delay_sup.sv
module rst_delay_sup #(
  parameter int LONG_TICKS  = 300,
  parameter int SHORT_TICKS = 20,
  parameter int PROG_W      = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [3:0]            sense_low,
  input  logic                  over_hi,
  input  logic                  mr_n,
  input  logic [7:0]            dly_sel,
  input  logic [4*PROG_W-1:0]   prog_ticks,
  output logic [3:0]            rst_out_n
);
  localparam int PROG_MAX = (1 << PROG_W) - 1;
  localparam int MAX_A    = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int MAX_T    = (MAX_A > PROG_MAX) ? MAX_A : PROG_MAX;
  localparam int CNT_W    = $clog2(MAX_T + 1);

  logic [5:0] raw_flt, sync1, sync2;
  logic [3:0] flt;
  logic [3:0] held;

  assign raw_flt = {over_hi, ~mr_n, sense_low};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= raw_flt;
      sync2 <= sync1;
    end
  end

  assign flt[0] = sync2[0] | sync2[4];
  assign flt[1] = sync2[1];
  assign flt[2] = sync2[2];
  assign flt[3] = sync2[3] | sync2[5];

  for (genvar i = 0; i < 4; i++) begin : g_ch
    logic [CNT_W-1:0]  cnt, tgt, nxt;
    logic [PROG_W-1:0] pv;

    assign pv  = prog_ticks[i*PROG_W +: PROG_W];
    assign nxt = cnt + 1'b1;

    always_comb begin
      case (dly_sel[2*i +: 2])
        2'b01:   tgt = CNT_W'(SHORT_TICKS);
        2'b10:   tgt = (pv == '0) ? CNT_W'(1) : CNT_W'(pv);
        default: tgt = CNT_W'(LONG_TICKS);
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[i] <= 1'b1;
        cnt     <= '0;
      end else if (flt[i]) begin
        held[i] <= 1'b1;
        cnt     <= '0;
      end else if (held[i] && tick) begin
        if (nxt >= tgt) begin
          held[i] <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= nxt;
        end
      end
    end

    assign rst_out_n[i] = ~(flt[i] | held[i]);
  end
endmodule

// File: rtl/rst_delay_sup_chk.sv
module rst_delay_sup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       mr_n,
  input logic       over_hi,
  input logic [3:0] flt,
  input logic [3:0] rst_out_n
);
  for (genvar i = 0; i < 4; i++) begin : g_a
    assert_release_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n[i]) |-> $past(tick));
    assert_release_when_healthy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n[i]) |-> !$past(flt[i]));
    assert_fall_only_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out_n[i]) |-> flt[i]);
  end

  assert_manual_holds_ch1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mr_n, 2) |-> !rst_out_n[0]);
  assert_over_holds_ch4_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(over_hi, 2) |-> !rst_out_n[3]);
endmodule

bind rst_delay_sup rst_delay_sup_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mr_n(mr_n), .over_hi(over_hi),
  .flt(flt), .rst_out_n(rst_out_n)
);

// File: tb/rst_delay_sup_tb_top.sv
`timescale 1ns/1ps
module rst_delay_sup_tb_top;
  localparam int BIG = 1000000;
  localparam int REL = -2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [3:0]  sense_low = 4'b0000;
  logic        over_hi = 1'b0;
  logic        mr_n = 1'b1;
  logic [7:0]  dly_sel = 8'b0;
  logic [13:0] pg [4];
  logic [3:0]  rst_out_n;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rst_delay_sup dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sense_low(sense_low),
    .over_hi(over_hi), .mr_n(mr_n), .dly_sel(dly_sel),
    .prog_ticks({pg[3], pg[2], pg[1], pg[0]}), .rst_out_n(rst_out_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int ch, input logic exp);
    total++;
    if (rst_out_n[ch] !== exp) begin
      bad++;
      $display("FAIL %s ch%0d actual=%b expected=%b", req, ch, rst_out_n[ch], exp);
    end
  endtask

  task automatic watch(input string req, input int cycles,
                       input int n0, input int n1, input int n2, input int n3);
    int nn[4];
    int miss[4];
    logic mact[4], mexp[4];
    int mk[4];
    nn = '{n0, n1, n2, n3};
    miss = '{0, 0, 0, 0};
    mk = '{0, 0, 0, 0};
    for (int k = 1; k <= cycles; k++) begin
      step(1);
      for (int c = 0; c < 4; c++) begin
        logic e;
        e = (k >= 2 + nn[c]);
        if (rst_out_n[c] !== e && miss[c] == 0) begin
          miss[c] = 1; mact[c] = rst_out_n[c]; mexp[c] = e; mk[c] = k;
        end
      end
    end
    for (int c = 0; c < 4; c++) begin
      total++;
      if (miss[c] != 0) begin
        bad++;
        $display("FAIL %s ch%0d cycle %0d actual=%b expected=%b", req, c, mk[c], mact[c], mexp[c]);
      end
    end
  endtask

  task automatic t_reset_modes();
    dly_sel = {2'b11, 2'b10, 2'b00, 2'b01};
    pg[2] = 14'd5;
    step(4);
    for (int c = 0; c < 4; c++) chk("R9 low in reset", c, 1'b0);
    rst_n = 1'b1;
    watch("R6 R5 R9 release by mode", 306, 20, 300, 5, 300);
  endtask

  task automatic t_assert();
    dly_sel = 8'b01010101;
    sense_low[1] = 1'b1;
    step(1);
    chk("R10 one edge not enough", 1, 1'b1);
    step(1);
    chk("R1 R4 asserted after sync", 1, 1'b0);
    sense_low[1] = 1'b0;
    watch("R1 R5 ch2 release", 25, REL, 20, REL, REL);
    sense_low = 4'b0101;
    step(2);
    chk("R1 ch1 asserted", 0, 1'b0);
    chk("R1 ch3 asserted", 2, 1'b0);
    chk("R1 ch4 untouched", 3, 1'b1);
    sense_low = 4'b0000;
    watch("R1 release ch1 ch3", 25, 20, REL, 20, REL);
  endtask

  task automatic t_manual();
    mr_n = 1'b0;
    step(2);
    chk("R2 manual asserts", 0, 1'b0);
    chk("R2 other channel free", 1, 1'b1);
    step(30);
    chk("R2 held while manual low", 0, 1'b0);
    mr_n = 1'b1;
    sense_low[0] = 1'b1;
    step(30);
    chk("R2 sense keeps hold", 0, 1'b0);
    sense_low[0] = 1'b0;
    watch("R2 release", 25, 20, REL, REL, REL);
  endtask

  task automatic t_window();
    over_hi = 1'b1;
    step(2);
    chk("R3 over asserts ch4", 3, 1'b0);
    chk("R3 ch1 free", 0, 1'b1);
    over_hi = 1'b0;
    watch("R3 release after over", 25, REL, REL, REL, 20);
    sense_low[3] = 1'b1;
    step(2);
    chk("R3 under asserts ch4", 3, 1'b0);
    sense_low[3] = 1'b0;
    watch("R3 release after under", 25, REL, REL, REL, 20);
  endtask

  task automatic t_restart();
    sense_low[0] = 1'b1;
    step(3);
    sense_low[0] = 1'b0;
    step(12);
    sense_low[0] = 1'b1;
    step(1);
    sense_low[0] = 1'b0;
    watch("R8 restart after glitch", 25, 20, REL, REL, REL);
  endtask

  task automatic t_coincide();
    sense_low[0] = 1'b1;
    step(3);
    sense_low[0] = 1'b0;
    step(19);
    sense_low[0] = 1'b1;
    step(1);
    sense_low[0] = 1'b0;
    watch("R8 fault on release edge", 25, 20, REL, REL, REL);
    mr_n = 1'b0;
    step(3);
    mr_n = 1'b1;
    sense_low[0] = 1'b1;
    step(3);
    chk("R2 handover no gap", 0, 1'b0);
    sense_low[0] = 1'b0;
    watch("R2 handover release", 25, 20, REL, REL, REL);
  endtask

  task automatic t_prog();
    dly_sel[5:4] = 2'b10;
    pg[2] = 14'd0;
    sense_low[2] = 1'b1;
    step(3);
    sense_low[2] = 1'b0;
    watch("R7 zero acts as one", 6, REL, REL, 1, REL);
    pg[2] = 14'd16383;
    sense_low[2] = 1'b1;
    step(3);
    sense_low[2] = 1'b0;
    watch("R7 max count", 16390, REL, REL, 16383, REL);
  endtask

  task automatic t_tick();
    tick = 1'b0;
    sense_low[0] = 1'b1;
    step(3);
    sense_low[0] = 1'b0;
    step(50);
    chk("R5 no ticks no release", 0, 1'b0);
    for (int t = 0; t < 19; t++) begin
      tick = 1'b1; step(1); tick = 1'b0; step(2);
    end
    chk("R5 nineteen ticks", 0, 1'b0);
    tick = 1'b1; step(1); tick = 1'b0;
    chk("R5 twentieth tick", 0, 1'b1);
    tick = 1'b1;
  endtask

  initial begin
    pg[0] = 14'd0; pg[1] = 14'd0; pg[2] = 14'd0; pg[3] = 14'd0;
    @(negedge clk);
    t_reset_modes();
    t_assert();
    t_manual();
    t_window();
    t_restart();
    t_coincide();
    t_prog();
    t_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule